// File: doc/BRIEF.md
# Level-Sensitive Interrupt Distributor with CPU Acknowledge Port

This block gathers level-sensitive interrupt request lines from a parameterized number of sources and presents at most one of them to a single processor. A register bus reaches two banks. The distributor bank holds a global forwarding switch, per-source enable bits and per-source routing bytes. The CPU-interface bank holds its own enable switch, a priority mask, an acknowledge register and an end-of-interrupt register.

Software first enables the sources it wants and routes them to CPU 0. It then opens both global switches and raises the priority mask. When the request output rises, the handler reads the acknowledge register. That read returns the winning source number and marks it active. When the handler has finished, it writes the same number to the end-of-interrupt register. Only one interrupt is active at a time. All sources share one fixed priority, so the lowest source number wins.

The bus uses address bit 12 to pick the bank: 0 selects the distributor and 1 selects the CPU interface. Bits 11:0 give the byte offset inside the bank. Writes are whole 32-bit words. Read data is combinational for the presented address, and the acknowledge side effect takes place at the clock edge on which the read is strobed.

Top module: `gic_lite`

## Requirements
- R1: After reset, cpu_irq is low, the distributor control word (offset 0x000), every enable word and the priority mask read 0, and an acknowledge read returns 1023.
- R2: Writing a 1 to bit N mod 32 of the enable word at distributor offset 0x100 + (N/32)*4 enables source N. Bits written as 0 leave their enables unchanged, and the word reads back the accumulated enables.
- R3: The routing byte of source N sits at distributor byte offset 0x800 + N. Its bit 0 (word bit 8*(N mod 4)) routes the source to CPU 0 and reads back. A source whose routing bit is 0 never raises cpu_irq, and acknowledge returns 1023 for it.
- R4: cpu_irq can be high only while bit 0 of the distributor control word (offset 0x000) and bit 0 of the CPU control word (CPU offset 0x00) are both 1. Clearing either one drops cpu_irq.
- R5: The priority mask at CPU offset 0x04 stores the low 8 bits written. Every source has priority 0xA0 and is forwarded only when 0xA0 is below the mask. Writing 0xFFFF therefore admits all sources and reads back 0xFF.
- R6: A read of CPU offset 0x0C while cpu_irq is high returns the winning source number and makes that source active. cpu_irq is low from the next cycle on.
- R7: When cpu_irq is low, an acknowledge read returns 1023 and changes no state.
- R8: While an interrupt is active, cpu_irq stays low and further acknowledge reads return 1023.
- R9: Writing the active source number to CPU offset 0x10 ends the active state. A write there with any other value is ignored, and cpu_irq then stays low.
- R10: Among sources that are high, enabled and routed, the lowest number wins. A source still high after its end-of-interrupt raises cpu_irq again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | N_IRQ | Level interrupt requests, one bit per source number |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the acknowledge side effect) |
| bus_addr | input | 13 | Bit 12 selects the bank, bits 11:0 are the byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cpu_irq | output | 1 | Interrupt request level to CPU 0 |

## Verification
A lost active flag shows at once: cpu_irq rises again in the cycle after an acknowledge while the source is still high, and a second acknowledge returns a number instead of 1023. An active flag that stays set after a valid end-of-interrupt holds cpu_irq low, and this is visible in the next cycle because the source is kept high. An enable bit or routing bit that is dropped or overwritten shows on the next acknowledge: either 1023 comes back, or a higher source number than expected wins. A wrong choice of winner shows directly in the acknowledge value for patterns with several sources high.

// File: rtl/gic_lite_pkg.sv
package gic_lite_pkg;
  localparam int unsigned SPURIOUS_ID = 1023;

  // distributor bank offsets
  localparam logic [11:0] DCTL_OFS   = 12'h000;
  localparam logic [11:0] SETEN_BASE = 12'h100;
  localparam logic [11:0] TGT_BASE   = 12'h800;

  // cpu interface bank offsets
  localparam logic [11:0] CCTL_OFS  = 12'h000;
  localparam logic [11:0] PMASK_OFS = 12'h004;
  localparam logic [11:0] ACK_OFS   = 12'h00C;
  localparam logic [11:0] EOI_OFS   = 12'h010;

  // word index (addr>>2) of the enable word holding source id
  function automatic int unsigned seten_word(int unsigned base_w, int unsigned id);
    return base_w + id / 32;
  endfunction

  // word index of the routing word holding source id; bit position is 8*(id%4)
  function automatic int unsigned tgt_word(int unsigned base_w, int unsigned id);
    return base_w + id / 4;
  endfunction

  function automatic int unsigned tgt_bit(int unsigned id);
    return 8 * (id % 4);
  endfunction

  // a priority is admitted when it is strictly below the mask
  function automatic logic prio_admit(logic [7:0] prio, logic [7:0] mask);
    return prio < mask;
  endfunction
endpackage

// File: rtl/gic_dist.sv
module gic_dist
  import gic_lite_pkg::*;
#(
  parameter int N_IRQ = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [11:0]      addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             dist_en,
  output logic [N_IRQ-1:0] enable,
  output logic [N_IRQ-1:0] target
);
  localparam int NW      = N_IRQ / 32;
  localparam int SETEN_W = int'(SETEN_BASE >> 2);
  localparam int TGT_W   = int'(TGT_BASE >> 2);

  logic [9:0] waddr;
  assign waddr = addr[11:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_en <= 1'b0;
      enable  <= '0;
      target  <= '0;
    end else if (wr) begin
      if (addr == DCTL_OFS) dist_en <= wdata[0];
      for (int w = 0; w < NW; w++) begin
        if (waddr == 10'(seten_word(SETEN_W, 32 * w)))
          enable[w*32 +: 32] <= enable[w*32 +: 32] | wdata;
      end
      for (int i = 0; i < N_IRQ; i++) begin
        if (waddr == 10'(tgt_word(TGT_W, i)))
          target[i] <= wdata[tgt_bit(i)];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == DCTL_OFS) rdata = {31'd0, dist_en};
    for (int w = 0; w < NW; w++) begin
      if (waddr == 10'(seten_word(SETEN_W, 32 * w))) rdata = enable[w*32 +: 32];
    end
    for (int i = 0; i < N_IRQ; i++) begin
      if (waddr == 10'(tgt_word(TGT_W, i))) rdata[tgt_bit(i)] = target[i];
    end
  end
endmodule

// File: rtl/gic_pick.sv
module gic_pick #(
  parameter int N_IRQ = 96,
  parameter int ID_W  = 10
) (
  input  logic [N_IRQ-1:0] cand,
  output logic             any,
  output logic [ID_W-1:0]  id
);
  always_comb begin
    id = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (cand[i]) id = ID_W'(i);
    end
  end
  assign any = |cand;
endmodule

// File: rtl/gic_cpuif.sv
module gic_cpuif
  import gic_lite_pkg::*;
#(
  parameter int         ID_W = 10,
  parameter logic [7:0] PRIO = 8'hA0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic [11:0]     addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic            dist_en,
  input  logic            cand_any,
  input  logic [ID_W-1:0] cand_id,
  output logic            cpu_en,
  output logic            cpu_irq,
  output logic            ack_evt,
  output logic            eoi_evt,
  output logic            active_vld,
  output logic [ID_W-1:0] active_id
);
  logic [7:0] pmask;
  logic       fwd;

  assign fwd     = dist_en & cpu_en & cand_any & prio_admit(PRIO, pmask) & ~active_vld;
  assign cpu_irq = fwd;
  assign ack_evt = rd & (addr == ACK_OFS) & fwd;
  assign eoi_evt = wr & (addr == EOI_OFS) & active_vld
                 & (wdata == 32'(active_id));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_en     <= 1'b0;
      pmask      <= '0;
      active_vld <= 1'b0;
      active_id  <= '0;
    end else begin
      if (wr && addr == CCTL_OFS)  cpu_en <= wdata[0];
      if (wr && addr == PMASK_OFS) pmask  <= wdata[7:0];
      if (ack_evt) begin
        active_vld <= 1'b1;
        active_id  <= cand_id;
      end else if (eoi_evt) begin
        active_vld <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      CCTL_OFS:  rdata = {31'd0, cpu_en};
      PMASK_OFS: rdata = {24'd0, pmask};
      ACK_OFS:   rdata = fwd ? 32'(cand_id) : 32'(SPURIOUS_ID);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gic_lite.sv
module gic_lite #(
  parameter int         N_IRQ = 96,
  parameter int         ID_W  = 10,
  parameter logic [7:0] PRIO  = 8'hA0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_src,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [12:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             cpu_irq
);
  logic             cpu_sel;
  logic [31:0]      dist_rdata, cpu_rdata;
  logic             dist_en, cpu_en;
  logic [N_IRQ-1:0] enable, target, cand;
  logic             cand_any;
  logic [ID_W-1:0]  cand_id;
  logic             ack_evt, eoi_evt, active_vld;
  logic [ID_W-1:0]  active_id;

  assign cpu_sel = bus_addr[12];
  assign cand    = irq_src & enable & target;

  gic_dist #(.N_IRQ(N_IRQ)) u_dist (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr & ~cpu_sel), .addr(bus_addr[11:0]),
    .wdata(bus_wdata), .rdata(dist_rdata), .dist_en(dist_en),
    .enable(enable), .target(target)
  );

  gic_pick #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_pick (
    .cand(cand), .any(cand_any), .id(cand_id)
  );

  gic_cpuif #(.ID_W(ID_W), .PRIO(PRIO)) u_cpuif (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr & cpu_sel), .rd(bus_rd & cpu_sel),
    .addr(bus_addr[11:0]), .wdata(bus_wdata), .rdata(cpu_rdata),
    .dist_en(dist_en), .cand_any(cand_any), .cand_id(cand_id),
    .cpu_en(cpu_en), .cpu_irq(cpu_irq), .ack_evt(ack_evt), .eoi_evt(eoi_evt),
    .active_vld(active_vld), .active_id(active_id)
  );

  assign bus_rdata = cpu_sel ? cpu_rdata : dist_rdata;
endmodule

// File: rtl/gic_lite_chk.sv
module gic_lite_chk #(
  parameter int ID_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_irq,
  input logic            dist_en,
  input logic            cpu_en,
  input logic            ack_evt,
  input logic            eoi_evt,
  input logic            active_vld,
  input logic [ID_W-1:0] active_id,
  input logic            bus_rd,
  input logic [12:0]     bus_addr,
  input logic [31:0]     bus_rdata
);
  AST_IRQ_NEEDS_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (dist_en && cpu_en)); // R4
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> (!cpu_irq && active_vld)); // R6
  AST_ACTIVE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    active_vld |-> !cpu_irq); // R8
  AST_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 13'h100C && !cpu_irq) |-> bus_rdata == 32'd1023); // R7
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_evt |=> !active_vld); // R9
  AST_ACTIVE_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_vld && !eoi_evt) |=> $stable(active_id)); // R8
endmodule

bind gic_lite gic_lite_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .dist_en(dist_en), .cpu_en(cpu_en),
  .ack_evt(ack_evt), .eoi_evt(eoi_evt), .active_vld(active_vld),
  .active_id(active_id), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/sim_gic_lite.sv
`timescale 1ns/1ps
module sim_gic_lite;
  localparam int N = 96;
  localparam logic [12:0] CPU = 13'h1000;

  logic         clk = 0, rst_n = 0;
  logic [N-1:0] irq_src = '0;
  logic         bus_wr = 0, bus_rd = 0;
  logic [12:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         cpu_irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  gic_lite u0 (.clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  // pattern of high sources, expected acknowledge value (R6, R7, R10)
  localparam logic [127:0] TBL [5] = '{
    {(96'd1 << 29) | (96'd1 << 73), 32'd29},
    {(96'd1 << 73),                 32'd73},
    {(96'd1 << 40) | (96'd1 << 73), 32'd40},
    {(96'd1 << 5),                  32'd1023},
    {96'd0,                         32'd1023}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic set_src(input logic [N-1:0] s);
    @(negedge clk); irq_src = s; #1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 chk(32'(cpu_irq), 0, "R1 irq after reset");
    rd(13'h000, d);     chk(d, 0, "R1 dist ctrl");
    rd(13'h100, d);     chk(d, 0, "R1 enable word0");
    rd(CPU | 13'h4, d); chk(d, 0, "R1 pmask");
    rd(CPU | 13'hC, d); chk(d, 1023, "R1 ack spurious");

    // R2 enables for 29, 40, 73
    wr(13'h100, 32'h1 << 29);
    wr(13'h104, 32'h1 << 8);
    wr(13'h108, 32'h1 << 9);
    wr(13'h100, 32'h0);
    rd(13'h100, d); chk(d, 32'h1 << 29, "R2 zero write no effect");
    wr(13'h100, 32'h1);
    rd(13'h100, d); chk(d, (32'h1 << 29) | 32'h1, "R2 enables accumulate");
    rd(13'h108, d); chk(d, 32'h200, "R2 enable word2");

    // R3 routing bytes: 29 -> 0x81D, 40 -> 0x828, 73 -> 0x849
    wr(13'h81C, 32'h100);
    wr(13'h828, 32'h1);
    wr(13'h848, 32'h100);
    rd(13'h81C, d); chk(d, 32'h100, "R3 route readback");

    // R4, R5 global enables and mask
    set_src(N'(1) << 29);
    chk(32'(cpu_irq), 0, "R4 both enables off");
    wr(13'h000, 1);
    chk(32'(cpu_irq), 0, "R4 cpu enable off");
    wr(CPU, 1);
    chk(32'(cpu_irq), 0, "R5 mask zero blocks");
    wr(CPU | 13'h4, 32'hA0);
    chk(32'(cpu_irq), 0, "R5 mask equal blocks");
    wr(CPU | 13'h4, 32'hFFFF);
    rd(CPU | 13'h4, d); chk(d, 32'hFF, "R5 mask low byte");
    chk(32'(cpu_irq), 1, "R4 forwarded");
    wr(13'h000, 0);
    chk(32'(cpu_irq), 0, "R4 dist off drops");
    wr(13'h000, 1);
    wr(CPU, 0);
    chk(32'(cpu_irq), 0, "R4 cpu off drops");
    wr(CPU, 1);

    // table walk
    for (int k = 0; k < 5; k++) begin
      logic [N-1:0] s;
      logic [31:0]  e;
      s = TBL[k][127:32];
      e = TBL[k][31:0];
      set_src(s);
      chk(32'(cpu_irq), (e != 1023) ? 1 : 0, "R10 irq level");
      rd(CPU | 13'hC, d); chk(d, e, "R6 ack id");
      if (e != 1023) begin
        chk(32'(cpu_irq), 0, "R6 irq drops after ack");
        rd(CPU | 13'hC, d); chk(d, 1023, "R8 second ack spurious");
        wr(CPU | 13'h10, e + 1);
        chk(32'(cpu_irq), 0, "R9 wrong eoi ignored");
        wr(CPU | 13'h10, e);
        chk(32'(cpu_irq), 1, "R10 reassert after eoi");
        rd(CPU | 13'hC, d); chk(d, e, "R10 same winner again");
        wr(CPU | 13'h10, e);
      end else begin
        chk(32'(cpu_irq), 0, "R7 no state change");
      end
    end

    // R3 unrouted source is never forwarded
    wr(13'h828, 32'h0);
    set_src(N'(1) << 40);
    chk(32'(cpu_irq), 0, "R3 unrouted irq");
    rd(CPU | 13'hC, d); chk(d, 1023, "R3 unrouted ack");
    set_src('0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule